// File: doc/BRIEF.md
# Windowed VGA Pixel Fetcher

This block drives a 640×480, 60 Hz raster and shows a small image inside it. Each axis has its own timer. Each timer is built from a phase register and a count within that phase. Together they produce active-low horizontal and vertical sync.

Inside a rectangular window of `IMG_W`×`IMG_H` pixels, the block reads the frame memory in raster order, one word per window pixel, at a linear address. It then drives the returned code onto an 8-bit palette pixel bus together with a pixel strobe. The window is 160×120 by default, with its top-left corner set by parameters. Everywhere outside the window, and during retrace, the blank output is held low.

Palette entries 0, 1 and 2 are reserved for overlay colours. Image codes below 3 are therefore raised to 3 before output. The memory read port has a fixed latency. Sync, blank and strobe are delayed to match that latency, so all outputs of one raster position appear in the same cycle.

Top module: `vga_win_fetcher`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks. `hsync_n` is low for exactly H_SYNC clocks, starting H_ACTIVE+H_FP clocks after the line's first visible pixel.
- R2: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines. `vsync_n` is low for exactly V_SYNC whole lines, starting V_ACTIVE+V_FP lines after the first visible line.
- R3: `blank_n` and `pal_clk` are high only at visible positions with column WIN_X0..WIN_X0+IMG_W-1 and row WIN_Y0..WIN_Y0+IMG_H-1. They are low at every other position, including all retrace.
- R4: `mem_rd` is high for one cycle per window pixel, IMG_W×IMG_H times per frame. `mem_addr` equals (row−WIN_Y0)×IMG_W + (column−WIN_X0), so it restarts at 0 every frame.
- R5: `mem_rdata` is taken RD_LAT cycles after the cycle `mem_rd` is high. It appears on `pix_data` in the same cycle as the sync and blank values of that raster position.
- R6: Within the window, a returned code of 0, 1 or 2 is output as 3. Any code of 3 or above is output unchanged.
- R7: Whenever `blank_n` is low, `pix_data` is 0. Data on `mem_rdata` outside a read's return slot has no effect on any output.
- R8: While `rst_n` is low, `hsync_n` and `vsync_n` are 1, and `blank_n`, `pal_clk`, `mem_rd` and `pix_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_rd | output | 1 | Frame-memory read strobe, one per window pixel |
| mem_addr | output | AW | Linear pixel address, valid when `mem_rd` is high |
| mem_rdata | input | DW | Read data, valid RD_LAT cycles after `mem_rd` |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | Low forces the palette output to blank |
| pal_clk | output | 1 | Pixel strobe, high in each cycle a new image pixel is on `pix_data` |
| pix_data | output | DW | Palette index (remapped image code, or 0 while blanked) |

## Verification
The bench shrinks the raster to 16-clock visible lines and 12 visible lines, with porches and sync of a few units each. It places a 6×4 window against the right edge of the visible area and on the top row, and sets RD_LAT to 2. A frame then takes a few hundred cycles, so two complete frames can be compared position by position. This brings several cases within reach: the address restart between frames, a window column that borders the front porch, a window row that starts the frame, and a multi-stage read pipeline. The memory model returns codes 0 to 2 inside the window and a nonzero code outside any return slot, which exercises both the remap and the blanking.

// File: rtl/vga_win_pkg.sv
package vga_win_pkg;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } vga_phase_e;

  typedef struct packed {
    logic hs_n;
    logic vs_n;
    logic win;
  } vga_ctl_t;

  localparam vga_ctl_t CTL_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, win: 1'b0};

endpackage

// File: rtl/vga_rst_sync.sv
module vga_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/vga_axis_timer.sv
module vga_axis_timer
  import vga_win_pkg::*;
#(
  parameter int ACTIVE = 640,
  parameter int FP     = 16,
  parameter int SYNC   = 96,
  parameter int BP     = 48,
  localparam int CW    = $clog2(ACTIVE + FP + SYNC + BP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] pos,
  output logic          act,
  output logic          sync_n,
  output logic          wrap
);

  vga_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] seg_last;
  logic          at_last;

  always_comb begin
    unique case (phase_q)
      PH_ACT:  seg_last = CW'(ACTIVE - 1);
      PH_FP:   seg_last = CW'(FP - 1);
      PH_SYNC: seg_last = CW'(SYNC - 1);
      default: seg_last = CW'(BP - 1);
    endcase
  end

  always_comb begin
    at_last = (cnt_q == seg_last);
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (adv) begin
      if (at_last) begin
        cnt_d   = '0;
        phase_d = vga_phase_e'(phase_q + 2'd1);
      end else begin
        cnt_d   = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ACT;
      cnt_q   <= '0;
    end else if (adv) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pos    = cnt_q;
  assign act    = (phase_q == PH_ACT);
  assign sync_n = (phase_q != PH_SYNC);
  assign wrap   = adv && at_last && (phase_q == PH_BP);

endmodule

// File: rtl/vga_win_fetch.sv
module vga_win_fetch
  import vga_win_pkg::*;
#(
  parameter int HW     = 10,
  parameter int VW     = 10,
  parameter int IMG_W  = 160,
  parameter int IMG_H  = 120,
  parameter int WIN_X0 = 240,
  parameter int WIN_Y0 = 180,
  parameter int RD_LAT = 1,
  parameter int DW     = 8,
  parameter int RESV   = 3,
  parameter int AW     = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_pos,
  input  logic          h_act,
  input  logic          h_sync_n,
  input  logic [VW-1:0] v_pos,
  input  logic          v_act,
  input  logic          v_sync_n,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          blank_n,
  output logic          pal_clk,
  output logic [DW-1:0] pix_data
);

  localparam int DEPTH = RD_LAT + 2;
  localparam logic [HW-1:0] X_LO = HW'(WIN_X0);
  localparam logic [HW-1:0] X_HI = HW'(WIN_X0 + IMG_W - 1);
  localparam logic [VW-1:0] Y_LO = VW'(WIN_Y0);
  localparam logic [VW-1:0] Y_HI = VW'(WIN_Y0 + IMG_H - 1);
  localparam logic [DW-1:0] CODE_MIN = DW'(RESV);

  logic          h_in, v_in, win_now;
  logic [AW-1:0] addr_q, addr_d;
  logic          rd_q;
  logic [AW-1:0] rd_addr_q;
  vga_ctl_t      ctl_now;
  vga_ctl_t      dly_q [DEPTH];
  logic [DW-1:0] code_fix, pix_d, pix_q;

  // Window decode on the live raster position.
  always_comb begin
    h_in    = h_act && (h_pos >= X_LO) && (h_pos <= X_HI);
    v_in    = v_act && (v_pos >= Y_LO) && (v_pos <= Y_HI);
    win_now = h_in && v_in;
    ctl_now = '{hs_n: h_sync_n, vs_n: v_sync_n, win: win_now};
  end

  // Linear address: advances per fetch, cleared on rows outside the window.
  always_comb begin
    addr_d = addr_q;
    if (!v_in)        addr_d = '0;
    else if (win_now) addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      addr_q <= addr_d;
      rd_q   <= win_now;
      if (win_now) rd_addr_q <= addr_q;
    end
  end

  // Control delay line matching the read round trip.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dly_q[i] <= CTL_IDLE;
    end else begin
      dly_q[0] <= ctl_now;
      for (int i = 1; i < DEPTH; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  // Reserved-code remap, applied only to window data.
  always_comb begin
    code_fix = (mem_rdata < CODE_MIN) ? CODE_MIN : mem_rdata;
    pix_d    = dly_q[DEPTH-2].win ? code_fix : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_d;
  end

  assign mem_rd   = rd_q;
  assign mem_addr = rd_addr_q;
  assign hsync_n  = dly_q[DEPTH-1].hs_n;
  assign vsync_n  = dly_q[DEPTH-1].vs_n;
  assign blank_n  = dly_q[DEPTH-1].win;
  assign pal_clk  = dly_q[DEPTH-1].win;
  assign pix_data = pix_q;

endmodule

// File: rtl/vga_win_fetcher.sv
module vga_win_fetcher #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int IMG_W    = 160,
  parameter int IMG_H    = 120,
  parameter int WIN_X0   = 240,
  parameter int WIN_Y0   = 180,
  parameter int RD_LAT   = 1,
  parameter int DW       = 8,
  parameter int RESV     = 3,
  localparam int AW      = $clog2(IMG_W * IMG_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          blank_n,
  output logic          pal_clk,
  output logic [DW-1:0] pix_data
);

  localparam int HW = $clog2(H_ACTIVE + H_FP + H_SYNC + H_BP);
  localparam int VW = $clog2(V_ACTIVE + V_FP + V_SYNC + V_BP);

  logic          srst_n;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          h_act, h_sync_n, h_wrap;
  logic          v_act, v_sync_n, v_wrap;

  vga_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  vga_axis_timer #(
    .ACTIVE (H_ACTIVE), .FP (H_FP), .SYNC (H_SYNC), .BP (H_BP)
  ) u_htim (
    .clk    (clk),
    .rst_n  (srst_n),
    .adv    (1'b1),
    .pos    (h_pos),
    .act    (h_act),
    .sync_n (h_sync_n),
    .wrap   (h_wrap)
  );

  vga_axis_timer #(
    .ACTIVE (V_ACTIVE), .FP (V_FP), .SYNC (V_SYNC), .BP (V_BP)
  ) u_vtim (
    .clk    (clk),
    .rst_n  (srst_n),
    .adv    (h_wrap),
    .pos    (v_pos),
    .act    (v_act),
    .sync_n (v_sync_n),
    .wrap   (v_wrap)
  );

  vga_win_fetch #(
    .HW (HW), .VW (VW), .IMG_W (IMG_W), .IMG_H (IMG_H),
    .WIN_X0 (WIN_X0), .WIN_Y0 (WIN_Y0), .RD_LAT (RD_LAT),
    .DW (DW), .RESV (RESV), .AW (AW)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (srst_n),
    .h_pos     (h_pos),
    .h_act     (h_act),
    .h_sync_n  (h_sync_n),
    .v_pos     (v_pos),
    .v_act     (v_act),
    .v_sync_n  (v_sync_n),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .hsync_n   (hsync_n),
    .vsync_n   (vsync_n),
    .blank_n   (blank_n),
    .pal_clk   (pal_clk),
    .pix_data  (pix_data)
  );

endmodule

// File: rtl/vga_win_fetcher_chk.sv
module vga_win_fetcher_chk #(
  parameter int H_SYNC = 96,
  parameter int IMG_W  = 160,
  parameter int IMG_H  = 120,
  parameter int DW     = 8,
  parameter int RESV   = 3,
  parameter int AW     = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          blank_n,
  input logic [DW-1:0] pix_data
);

  logic [15:0] hs_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hs_low_q <= '0;
    else if (hsync_n) hs_low_q <= '0;
    else              hs_low_q <= hs_low_q + 16'd1;
  end

  p_hsync_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> (hs_low_q == 16'(H_SYNC)));

  p_no_pix_in_retrace_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> !blank_n);

  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (32'(mem_addr) < IMG_W * IMG_H));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  p_no_reserved_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blank_n |-> (pix_data >= DW'(RESV)));

  p_zero_when_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (pix_data == '0));

endmodule

bind vga_win_fetcher vga_win_fetcher_chk #(
  .H_SYNC (H_SYNC), .IMG_W (IMG_W), .IMG_H (IMG_H),
  .DW (DW), .RESV (RESV), .AW (AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .hsync_n  (hsync_n),
  .vsync_n  (vsync_n),
  .blank_n  (blank_n),
  .pix_data (pix_data)
);

// File: tb/vga_win_fetcher_tb.sv
`timescale 1ns/1ps
module vga_win_fetcher_tb;

  localparam int HA = 16, HF = 2, HS = 3, HB = 3;
  localparam int VA = 12, VF = 1, VS = 2, VB = 2;
  localparam int IW = 6, IH = 4, X0 = 10, Y0 = 0;
  localparam int LAT = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int NPIX = IW * IH;
  localparam int DEPTH = LAT + 2;
  localparam int FRAMES = 2;
  localparam int AW = $clog2(NPIX);

  typedef struct packed {
    logic       hs;
    logic       vs;
    logic       bl;
    logic [7:0] px;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;
  logic          hsync_n, vsync_n, blank_n, pal_clk;
  logic [7:0]    pix_data;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  exp_t sb_q[$];
  logic [7:0] lat_q [LAT];

  vga_win_fetcher #(
    .H_ACTIVE (HA), .H_FP (HF), .H_SYNC (HS), .H_BP (HB),
    .V_ACTIVE (VA), .V_FP (VF), .V_SYNC (VS), .V_BP (VB),
    .IMG_W (IW), .IMG_H (IH), .WIN_X0 (X0), .WIN_Y0 (Y0),
    .RD_LAT (LAT), .DW (8), .RESV (3)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .mem_rd (mem_rd), .mem_addr (mem_addr),
    .mem_rdata (mem_rdata), .hsync_n (hsync_n), .vsync_n (vsync_n),
    .blank_n (blank_n), .pal_clk (pal_clk), .pix_data (pix_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] mem_word(int a);
    return (a < 12) ? 8'(a) : 8'(200 + a);
  endfunction

  // Memory model: LAT-stage read pipeline; code 1 when no read is pending.
  always @(posedge clk) begin
    lat_q[0] <= mem_rd ? mem_word(int'(mem_addr)) : 8'd1;
    for (int i = 1; i < LAT; i++) lat_q[i] <= lat_q[i-1];
  end
  assign mem_rdata = lat_q[LAT-1];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Driver: expected output per raster position.
  task automatic push_frame();
    for (int v = 0; v < VT; v++) begin
      for (int h = 0; h < HT; h++) begin
        exp_t e;
        logic win;
        int   a;
        logic [7:0] w;
        win  = (h >= X0) && (h < X0 + IW) && (v >= Y0) && (v < Y0 + IH);
        e.hs = !((h >= HA + HF) && (h < HA + HF + HS));
        e.vs = !((v >= VA + VF) && (v < VA + VF + VS));
        e.bl = win;
        a    = (v - Y0) * IW + (h - X0);
        w    = mem_word(a);
        e.px = !win ? 8'd0 : ((w < 8'd3) ? 8'd3 : w);
        sb_q.push_back(e);
      end
    end
  endtask

  initial begin
    int rd_idx;
    int rd_cnt;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk("R8 hsync_n in reset", int'(hsync_n), 1);
    chk("R8 vsync_n in reset", int'(vsync_n), 1);
    chk("R8 blank_n in reset", int'(blank_n), 0);
    chk("R8 pal_clk in reset", int'(pal_clk), 0);
    chk("R8 mem_rd in reset", int'(mem_rd), 0);
    chk("R8 pix_data in reset", int'(pix_data), 0);
    for (int f = 0; f < FRAMES; f++) push_frame();
    rst_n = 1'b1;
    @(posedge clk);
    repeat (DEPTH + 1) @(posedge clk);
    rd_idx = 0;
    rd_cnt = 0;
    for (int p = 0; p < FRAMES * HT * VT; p++) begin
      exp_t e;
      @(negedge clk);
      e = sb_q.pop_front();
      if (hsync_n !== e.hs) chk("R1 hsync_n", int'(hsync_n), int'(e.hs));
      else n_chk++;
      if (vsync_n !== e.vs) chk("R2 vsync_n", int'(vsync_n), int'(e.vs));
      else n_chk++;
      if (blank_n !== e.bl) chk("R3 blank_n", int'(blank_n), int'(e.bl));
      else n_chk++;
      if (pal_clk !== e.bl) chk("R3 pal_clk", int'(pal_clk), int'(e.bl));
      else n_chk++;
      if (pix_data !== e.px)
        chk(e.bl ? "R5/R6 pix_data in window" : "R7 pix_data blanked",
            int'(pix_data), int'(e.px));
      else n_chk++;
      if (mem_rd === 1'b1) begin
        chk("R4 mem_addr linear", int'(mem_addr), rd_idx);
        rd_idx = (rd_idx + 1) % NPIX;
        rd_cnt++;
      end
      if ((p % (HT * VT)) == HT * VT - 1) begin
        chk("R4 reads per frame", rd_cnt, NPIX);
        rd_cnt = 0;
      end
      @(posedge clk);
    end
    done = 1;
    summary();
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

endmodule